// File: doc/BRIEF.md
# Flash Read-Back and Modification Guard

This block sits between a serial programming command port and an on-chip flash store made of a main block and a small information page. It keeps an 8-bit status register and decides which commands may reach the flash. Two protection flags come from two reserved information-page bytes. One flag hides the information page from read-back. The other hides the main block, and it also blocks page erase and byte write in both regions. A behavioural flash array is part of the block. The array starts erased to 0xFF and keeps its contents across controller resets.

Every command is a one-cycle `cmd_valid` pulse that carries an opcode, an address and a data byte. A read answers one cycle later on `rsp_valid`/`rsp_data`. A refused command raises `cmd_err` for one cycle. A command that changes the flash holds the busy bit for a fixed number of cycles, and the block ignores new commands during that time. When the command completes, the block reads both protection flags again from the reserved bytes. The status-register bit to which a command applies is chosen by the region-select bit: 0 targets the main block and 1 targets the information page.

Top module: `flash_guard`

## Requirements
- R1: The status register packs debug (bit 7), write enable (bit 5), busy (bit 4), region select (bit 3), main-block lock (bit 2) and information-page lock (bit 1). Bits 6 and 0 always read 0. Command 7 copies data bits 7, 5 and 3 into bits 7, 5 and 3 and leaves every other bit unchanged.
- R2: While reset is held, the status reads 0x16: busy set and both locks set. After reset is released, the startup scan keeps busy at 1 for exactly BUSY_CYC cycles.
- R3: When the region's lock is clear, a read (command 1) returns, one cycle after acceptance, the stored byte at the address in the region chosen by bit 3, with `rsp_valid` high and `cmd_err` low.
- R4: When the region's lock is set, a read returns 0x00 with `rsp_valid` and a one-cycle `cmd_err`. Each region has its own lock, so a lock on one region does not affect reads of the other.
- R5: A byte write (command 2) stores the old byte AND the data, so a write can only clear bits.
- R6: A page erase (command 3) sets to 0xFF the 32-byte main page that holds the address (address bits 7:5), or the whole information page when bit 3 is set. Bytes outside that page keep their values.
- R7: Commands 2 to 6 are refused unless write enable is 1. A refused command gives a one-cycle `cmd_err` and changes neither the flash nor write enable. Write enable returns to 0 when an accepted command completes.
- R8: While the main-block lock is 1, write and page erase are refused with `cmd_err` in both regions.
- R9: Command 5 clears information-page byte 0x22 and command 6 clears byte 0x23. The matching lock (bit 1 or bit 2) reads 1 once the command completes.
- R10: Erase-all (command 4) is accepted with write enable whatever the locks are. It sets both regions to 0xFF, and both locks read 0 once it completes.
- R11: Every accepted command 2 to 6 holds busy at 1 for exactly BUSY_CYC cycles. Any command presented while busy is 1 gives no response and no error and changes no state.
- R12: At every startup, and at the end of every flash-changing command, the information-page lock becomes (byte 0x22 != 0xFF) and the main-block lock becomes (byte 0x23 != 0xFF). The locks change at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low restart of the controller (flash keeps its contents) |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Opcode: 1 read, 2 write, 3 page erase, 4 erase-all, 5 lock info page, 6 lock main block, 7 write status |
| cmd_addr | input | MAIN_AW | Byte address (low INFO_AW bits used for the information page) |
| cmd_wdata | input | 8 | Write data or new status bits |
| status | output | 8 | Status register |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 8 | Read response byte |
| cmd_err | output | 1 | One-cycle pulse for a refused command or a read of a protected region |

## Verification
A wrong lock bit shows up on the next read of the affected region: a region that should be open returns 0x00 with an error, or a protected region leaks its stored byte. A lock bit that should be clear can also refuse a write or page erase, which the next read-back of that byte reveals. A write-enable bit left set after completion shows in the status one cycle after busy drops. A busy counter that runs too long or too short changes the number of busy samples and lets a command that should be ignored reach the flash. The bench keeps a full shadow of both regions, so after any corrupted array update the first read of that byte exposes it.

// File: rtl/fg_pkg.sv
package fg_pkg;

    typedef enum logic [2:0] {
        OP_IDLE       = 3'd0,
        OP_READ       = 3'd1,
        OP_WRITE      = 3'd2,
        OP_PAGE_ERASE = 3'd3,
        OP_ERASE_ALL  = 3'd4,
        OP_LOCK_INFO  = 3'd5,
        OP_LOCK_MAIN  = 3'd6,
        OP_SET_STATUS = 3'd7
    } fg_op_e;

    localparam int ST_DEBUG   = 7;
    localparam int ST_WREN    = 5;
    localparam int ST_REGION  = 3;

    localparam logic [7:0] ERASED = 8'hFF;

    typedef struct packed {
        logic       debug;
        logic       wren;
        logic       region;
        logic       lock_main;
        logic       lock_info;
        logic       rsp_valid;
        logic [7:0] rsp_data;
        logic       err;
    } fg_state_t;

endpackage

// File: rtl/fg_busy_timer.sv
module fg_busy_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    // Restart begins with the startup scan already counting.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CW'(CYCLES);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

endmodule

// File: rtl/fg_array.sv
module fg_array #(
    parameter int MAIN_AW  = 8,
    parameter int INFO_AW  = 6,
    parameter int PAGE_AW  = 5,
    parameter int INFO_OFS = 34,
    parameter int MAIN_OFS = 35
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic               pe_en,
    input  logic               ea_en,
    input  logic               sel_info,
    input  logic [MAIN_AW-1:0] addr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    output logic [7:0]         info_key,
    output logic [7:0]         main_key
);
    import fg_pkg::*;

    localparam int MAIN_N = 1 << MAIN_AW;
    localparam int INFO_N = 1 << INFO_AW;
    localparam int PAGE_N = 1 << PAGE_AW;

    logic [7:0] main_mem [MAIN_N];
    logic [7:0] info_mem [INFO_N];

    // Behavioural model: the part leaves the factory erased.
    initial begin
        for (int i = 0; i < MAIN_N; i++) main_mem[i] = ERASED;
        for (int i = 0; i < INFO_N; i++) info_mem[i] = ERASED;
    end

    always_ff @(posedge clk) begin
        if (ea_en) begin
            for (int i = 0; i < MAIN_N; i++) main_mem[i] <= ERASED;
            for (int i = 0; i < INFO_N; i++) info_mem[i] <= ERASED;
        end else if (pe_en) begin
            if (sel_info) begin
                for (int i = 0; i < INFO_N; i++) info_mem[i] <= ERASED;
            end else begin
                for (int j = 0; j < PAGE_N; j++) begin
                    main_mem[{addr[MAIN_AW-1:PAGE_AW], PAGE_AW'(j)}] <= ERASED;
                end
            end
        end else if (wr_en) begin
            if (sel_info) begin
                info_mem[addr[INFO_AW-1:0]] <= info_mem[addr[INFO_AW-1:0]] & wdata;
            end else begin
                main_mem[addr] <= main_mem[addr] & wdata;
            end
        end
    end

    assign rdata    = sel_info ? info_mem[addr[INFO_AW-1:0]] : main_mem[addr];
    assign info_key = info_mem[INFO_OFS];
    assign main_key = info_mem[MAIN_OFS];

endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
    parameter int MAIN_AW  = 8,
    parameter int INFO_AW  = 6,
    parameter int PAGE_AW  = 5,
    parameter int BUSY_CYC = 4,
    parameter int INFO_OFS = 34,
    parameter int MAIN_OFS = 35
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [MAIN_AW-1:0] cmd_addr,
    input  logic [7:0]         cmd_wdata,
    output logic [7:0]         status,
    output logic               rsp_valid,
    output logic [7:0]         rsp_data,
    output logic               cmd_err
);
    import fg_pkg::*;

    fg_state_t st_d, st_q;

    logic               busy, done, tmr_start;
    logic               arr_wr, arr_pe, arr_ea, arr_info;
    logic [MAIN_AW-1:0] arr_addr;
    logic [7:0]         arr_wdata, arr_rdata, info_key, main_key;
    logic               region_locked;
    fg_op_e             op;

    assign op            = fg_op_e'(cmd_op);
    assign region_locked = st_q.region ? st_q.lock_info : st_q.lock_main;

    fg_busy_timer #(.CYCLES(BUSY_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (busy),
        .done  (done)
    );

    fg_array #(
        .MAIN_AW  (MAIN_AW),
        .INFO_AW  (INFO_AW),
        .PAGE_AW  (PAGE_AW),
        .INFO_OFS (INFO_OFS),
        .MAIN_OFS (MAIN_OFS)
    ) u_array (
        .clk      (clk),
        .wr_en    (arr_wr),
        .pe_en    (arr_pe),
        .ea_en    (arr_ea),
        .sel_info (arr_info),
        .addr     (arr_addr),
        .wdata    (arr_wdata),
        .rdata    (arr_rdata),
        .info_key (info_key),
        .main_key (main_key)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.err       = 1'b0;
        tmr_start      = 1'b0;
        arr_wr         = 1'b0;
        arr_pe         = 1'b0;
        arr_ea         = 1'b0;
        arr_info       = st_q.region;
        arr_addr       = cmd_addr;
        arr_wdata      = cmd_wdata;

        if (done) begin
            // Completion of startup scan or of a flash change: rebuild the locks.
            st_d.lock_info = (info_key != ERASED);
            st_d.lock_main = (main_key != ERASED);
            st_d.wren      = 1'b0;
        end else if (cmd_valid && !busy) begin
            unique case (op)
                OP_READ: begin
                    st_d.rsp_valid = 1'b1;
                    if (region_locked) begin
                        st_d.rsp_data = 8'h00;
                        st_d.err      = 1'b1;
                    end else begin
                        st_d.rsp_data = arr_rdata;
                    end
                end
                OP_WRITE, OP_PAGE_ERASE: begin
                    if (!st_q.wren || st_q.lock_main) begin
                        st_d.err = 1'b1;
                    end else begin
                        arr_wr    = (op == OP_WRITE);
                        arr_pe    = (op == OP_PAGE_ERASE);
                        tmr_start = 1'b1;
                    end
                end
                OP_ERASE_ALL: begin
                    if (!st_q.wren) begin
                        st_d.err = 1'b1;
                    end else begin
                        arr_ea    = 1'b1;
                        tmr_start = 1'b1;
                    end
                end
                OP_LOCK_INFO, OP_LOCK_MAIN: begin
                    if (!st_q.wren) begin
                        st_d.err = 1'b1;
                    end else begin
                        arr_wr    = 1'b1;
                        arr_info  = 1'b1;
                        arr_addr  = (op == OP_LOCK_INFO) ? MAIN_AW'(INFO_OFS) : MAIN_AW'(MAIN_OFS);
                        arr_wdata = 8'h00;
                        tmr_start = 1'b1;
                    end
                end
                OP_SET_STATUS: begin
                    st_d.debug  = cmd_wdata[ST_DEBUG];
                    st_d.wren   = cmd_wdata[ST_WREN];
                    st_d.region = cmd_wdata[ST_REGION];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{debug: 1'b0, wren: 1'b0, region: 1'b0,
                      lock_main: 1'b1, lock_info: 1'b1,
                      rsp_valid: 1'b0, rsp_data: 8'h00, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign status    = {st_q.debug, 1'b0, st_q.wren, busy, st_q.region,
                        st_q.lock_main, st_q.lock_info, 1'b0};
    assign rsp_valid = st_q.rsp_valid;
    assign rsp_data  = st_q.rsp_data;
    assign cmd_err   = st_q.err;

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic [7:0] status,
    input logic       rsp_valid,
    input logic [7:0] rsp_data,
    input logic       cmd_err
);

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6] == 1'b0) && (status[0] == 1'b0)); // R1

    AST_PROT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && cmd_err) |-> (rsp_data == 8'h00)); // R4

    AST_WEN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[4]) |-> !status[5]); // R7

    AST_MB_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !status[4] && status[2] && (cmd_op == 3'd2 || cmd_op == 3'd3))
        |=> cmd_err); // R8

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && status[4]) |=> (!rsp_valid && !cmd_err)); // R11

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[4] && !$past(status[4])) |-> $stable(status[2:1])); // R12

endmodule

bind flash_guard flash_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .status    (status),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .cmd_err   (cmd_err)
);

// File: tb/tb_flash_guard.sv
module tb_flash_guard;
    localparam int BUSY = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_addr = 8'h00;
    logic [7:0] cmd_wdata = 8'h00;
    logic [7:0] status, rsp_data;
    logic       rsp_valid, cmd_err;

    always #5 clk = ~clk;

    flash_guard #(.BUSY_CYC(BUSY)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .status    (status),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .cmd_err   (cmd_err)
    );

    int total = 0;
    int bad   = 0;

    logic [7:0] m_main [256];
    logic [7:0] m_info [64];
    logic m_dbg, m_wen, m_infen, m_lmb, m_lip;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {m_dbg, 1'b0, m_wen, 1'b0, m_infen, m_lmb, m_lip, 1'b0};
    endfunction

    task automatic rescan();
        m_lip = (m_info[34] != 8'hFF);
        m_lmb = (m_info[35] != 8'hFF);
    endtask

    task automatic apply_mod(input logic [2:0] op, input logic [7:0] addr, input logic [7:0] data);
        case (op)
            3'd2: if (m_infen) m_info[addr[5:0]] = m_info[addr[5:0]] & data;
                  else         m_main[addr]      = m_main[addr] & data;
            3'd3: if (m_infen) for (int i = 0; i < 64; i++) m_info[i] = 8'hFF;
                  else for (int j = 0; j < 32; j++) m_main[{addr[7:5], 5'(j)}] = 8'hFF;
            3'd4: begin
                for (int i = 0; i < 256; i++) m_main[i] = 8'hFF;
                for (int i = 0; i < 64; i++)  m_info[i] = 8'hFF;
            end
            3'd5: m_info[34] = 8'h00;
            3'd6: m_info[35] = 8'h00;
            default: ;
        endcase
    endtask

    task automatic do_reset();
        int nb;
        nb = 0;
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 reset status", status, 8'h16);
        rst_n = 1'b1;
        cmd_op = 3'd1;
        cmd_addr = 8'h00;
        while (status[4]) begin
            nb++;
            chk("R11 startup rsp", rsp_valid, 0);
            chk("R11 startup err", cmd_err, 0);
            cmd_valid = 1'b1;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk("R2 startup busy", nb, BUSY);
        m_dbg = 0; m_wen = 0; m_infen = 0;
        rescan();
        chk("R12 startup flags", status, exp_status());
    endtask

    task automatic exec(input logic [2:0] op, input logic [7:0] addr, input logic [7:0] data);
        logic e_err, e_rv, modf;
        logic [7:0] e_rd;
        string tag;
        int nb;
        while (status[4]) @(negedge clk);
        e_err = 0; e_rv = 0; e_rd = 8'h00; modf = 0; tag = "R1";
        case (op)
            3'd1: begin
                e_rv = 1;
                if (m_infen ? m_lip : m_lmb) begin e_err = 1; tag = "R4"; end
                else begin tag = "R3"; e_rd = m_infen ? m_info[addr[5:0]] : m_main[addr]; end
            end
            3'd2, 3'd3: begin
                tag = (op == 3'd2) ? "R5" : "R6";
                if (!m_wen) begin e_err = 1; tag = "R7"; end
                else if (m_lmb) begin e_err = 1; tag = "R8"; end
                else modf = 1;
            end
            3'd4, 3'd5, 3'd6: begin
                tag = (op == 3'd4) ? "R10" : "R9";
                if (!m_wen) begin e_err = 1; tag = "R7"; end
                else modf = 1;
            end
            default: tag = "R1";
        endcase
        cmd_op = op; cmd_addr = addr; cmd_wdata = data; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk({tag, " rsp_valid"}, rsp_valid, e_rv);
        chk({tag, " err"}, cmd_err, e_err);
        if (e_rv) chk({tag, " data"}, rsp_data, e_rd);
        if (modf) begin
            apply_mod(op, addr, data);
            nb = 0;
            while (status[4]) begin nb++; @(negedge clk); end
            chk("R11 busy length", nb, BUSY);
            m_wen = 0;
            rescan();
        end else begin
            if (op == 3'd7) begin m_dbg = data[7]; m_wen = data[5]; m_infen = data[3]; end
            @(negedge clk);
            chk({tag, " err pulse"}, cmd_err, 0);
            chk({tag, " rsp pulse"}, rsp_valid, 0);
        end
        chk({tag, " status"}, status, exp_status());
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) m_main[i] = 8'hFF;
        for (int i = 0; i < 64; i++)  m_info[i] = 8'hFF;
        m_dbg = 0; m_wen = 0; m_infen = 0; m_lmb = 1; m_lip = 1;
        void'($urandom(32'd4242));

        do_reset();

        // R1: writable bits only, reserved bits stay 0
        exec(3'd7, 8'h00, 8'hFF);
        chk("R1 layout", status, 8'hA8);
        exec(3'd7, 8'h00, 8'h00);

        // R7: write without enable refused, flash untouched
        exec(3'd2, 8'h10, 8'h00);
        exec(3'd1, 8'h10, 8'h00);

        // R5: bits only cleared
        exec(3'd7, 8'h00, 8'h20); exec(3'd2, 8'h10, 8'h0F);
        exec(3'd7, 8'h00, 8'h20); exec(3'd2, 8'h10, 8'hF0);
        exec(3'd1, 8'h10, 8'h00);
        chk("R5 and-write", rsp_data, 8'h00);

        // R6: page boundaries
        foreach (m_main[k]) if (k == 8'h1F || k == 8'h20 || k == 8'h3F || k == 8'h40) begin
            exec(3'd7, 8'h00, 8'h20); exec(3'd2, 8'(k), 8'h00);
        end
        exec(3'd7, 8'h00, 8'h20); exec(3'd3, 8'h25, 8'h00);
        exec(3'd1, 8'h1F, 8'h00); chk("R6 below page", rsp_data, 8'h00);
        exec(3'd1, 8'h20, 8'h00); chk("R6 page start", rsp_data, 8'hFF);
        exec(3'd1, 8'h3F, 8'h00); chk("R6 page end", rsp_data, 8'hFF);
        exec(3'd1, 8'h40, 8'h00); chk("R6 above page", rsp_data, 8'h00);

        // R3: information page region
        exec(3'd7, 8'h00, 8'h28); exec(3'd2, 8'h05, 8'h5A);
        exec(3'd7, 8'h00, 8'h08); exec(3'd1, 8'h05, 8'h00);
        chk("R3 info read", rsp_data, 8'h5A);
        exec(3'd7, 8'h00, 8'h00);

        // R11: commands during an erase-all are ignored
        exec(3'd7, 8'h00, 8'h20);
        cmd_op = 3'd4; cmd_valid = 1'b1;
        @(negedge clk);
        chk("R10 busy start", status[4], 1);
        apply_mod(3'd4, 8'h00, 8'h00);
        cmd_op = 3'd7; cmd_wdata = 8'h88;
        @(negedge clk);
        chk("R11 ignored status write", rsp_valid | cmd_err, 0);
        cmd_op = 3'd1;
        @(negedge clk);
        chk("R11 ignored read", rsp_valid | cmd_err, 0);
        cmd_valid = 1'b0;
        while (status[4]) @(negedge clk);
        m_wen = 0; rescan();
        chk("R11 state untouched", status, exp_status());

        // R9, R4, R12: information page lock persists over restart
        exec(3'd7, 8'h00, 8'h20); exec(3'd2, 8'h33, 8'hA5);
        exec(3'd7, 8'h00, 8'h20); exec(3'd5, 8'h00, 8'h00);
        chk("R9 info lock", status[1], 1);
        exec(3'd7, 8'h00, 8'h08); exec(3'd1, 8'h05, 8'h00);
        exec(3'd7, 8'h00, 8'h00); exec(3'd1, 8'h33, 8'h00);
        chk("R4 main still open", rsp_data, 8'hA5);
        do_reset();
        chk("R12 info lock kept", status[2:1], 2'b01);

        // R8: main lock blocks writes and page erase in both regions
        exec(3'd7, 8'h00, 8'h20); exec(3'd6, 8'h00, 8'h00);
        exec(3'd7, 8'h00, 8'h20); exec(3'd2, 8'h33, 8'h00);
        exec(3'd7, 8'h00, 8'h28); exec(3'd3, 8'h00, 8'h00);
        exec(3'd7, 8'h00, 8'h00); exec(3'd1, 8'h33, 8'h00);
        do_reset();
        chk("R12 both locks kept", status[2:1], 2'b11);

        // R10: erase-all needs enable, then clears both locks
        exec(3'd4, 8'h00, 8'h00);
        exec(3'd7, 8'h00, 8'h20); exec(3'd4, 8'h00, 8'h00);
        chk("R10 locks cleared", status[2:1], 2'b00);
        exec(3'd7, 8'h00, 8'h08); exec(3'd1, 8'h22, 8'h00);
        chk("R10 key erased", rsp_data, 8'hFF);

        // Constrained random phase
        for (int it = 0; it < 600; it++) begin
            int r;
            logic [7:0] a, d;
            r = $urandom_range(99);
            a = 8'($urandom);
            d = 8'($urandom);
            if (r < 40)      exec(3'd1, a, d);
            else if (r < 52) exec(3'd2, a, d);
            else if (r < 58) exec(3'd3, a, d);
            else if (r < 82) exec(3'd7, a, {d[7], 1'b0, ($urandom_range(3) != 0), 1'b0, d[3], 3'b000});
            else if (r < 85) exec(3'd5, a, d);
            else if (r < 87) exec(3'd6, a, d);
            else if (r < 93) exec(3'd4, a, d);
            else if (r < 95) do_reset();
            else             exec(3'd1, {2'b00, 6'(34 + (r & 1))}, d);
        end

        summary();
        $finish;
    end

endmodule